// File: doc/BRIEF.md
# Step-Direction Microstep Write Sequencer

This block lets a plain step/direction source drive a dual-winding microstep current register through its byte-wide write port, with no processor in the loop. A rising edge on the step input moves a 64-position electrical-angle counter up or down. Each counter position picks a pair of sign-plus-magnitude current codes from an internal sine/cosine table. The block then runs chip-select, address and write-strobe cycles on the port so that the register bank takes the codes in.

Right after reset the block first loads the fast-decay threshold register of each winding from a pair of configuration inputs. After that it serves steps. In double-pulse mode every step loads winding 1 and then winding 2, with no idle cycle between the two writes. In single-pulse mode every step loads only one winding, and the winding alternates from step to step, so any two neighbouring writes form an intermediate position. Steps that arrive while writes are still running are queued as a signed net count, and a busy output reports outstanding work.

Top module: `ustep_write_seq`

## Requirements
- R1: After reset, csN and wrN are high and dataOut is 0. The first two writes are a threshold load for winding 1 (addr 2'b10) followed by one for winding 2 (addr 2'b11). Each carries its 3-bit threshold input in data bits 6:4, and all other data bits are 0. No threshold write occurs after the first step write.
- R2: One write cycle holds csN low for WR_LOW+1 clocks. wrN is low for the first WR_LOW of those clocks and high for the final hold clock. addr and dataOut stay constant through the whole cycle, and the register port takes the data on the wrN rising edge.
- R3: A rising edge on stepIn moves the position by +1 when dirUp is 1 and by -1 when it is 0, modulo 64. The position is 0 after reset.
- R4: Step writes use addr 2'b00 for winding 1 and 2'b01 for winding 2. The winding 1 code at position p has bit 7 set for p in 32..63 and bits 6:0 = round(127*|sin(2*pi*p/64)|). The winding 2 code has bit 7 set for p in 16..47 and bits 6:0 = round(127*|cos(2*pi*p/64)|).
- R5: With singleMode low, each step gives a winding 1 write followed by a winding 2 write. Both use the new position, and their wrN rising edges are exactly WR_LOW+1 clocks apart.
- R6: With singleMode high, each step gives exactly one write, for the winding whose turn it is. Turns alternate and begin with winding 1 after reset. Steps served in double mode leave the turn unchanged.
- R7: Steps that arrive while writes are in progress are queued as a net count, with up adding 1 and down subtracting 1. They are served one per sequence, and an up step and a down step that are both still queued cancel each other. The queue saturates at its signed limits.
- R8: busy is high within one clock after a step edge is taken. It stays high while any write or queued step remains, and then falls.
- R9: When no work is queued, csN and wrN stay high and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepIn | input | 1 | Step request, rising edge taken |
| dirUp | input | 1 | Direction: 1 counts up, 0 counts down |
| singleMode | input | 1 | 1 selects single-pulse mode, 0 selects double-pulse mode |
| lvl1 | input | 3 | Fast-decay threshold for winding 1 |
| lvl2 | input | 3 | Fast-decay threshold for winding 2 |
| csN | output | 1 | Chip select, active low |
| wrN | output | 1 | Write strobe, data taken on rising edge |
| addr | output | 2 | Bit 1 selects the threshold register, bit 0 selects the winding |
| dataOut | output | 8 | Write data byte |
| busy | output | 1 | Work outstanding |

## Verification
The case that is hardest to reach from the ports is a step edge, or a pair of opposing edges, that lands while a write sequence is already driving the bus. The queue then moves without anything being consumed. The stimulus gets there by firing a step, then fixing its next edges two clocks apart, so they fall inside the six-clock double write that the first step started. The resulting count of writes and the position of the next step then show whether the queue added, cancelled or lost those edges. Mode switching between single and double steps is mixed in the same way, which shows that the winding turn carries across double-mode steps.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int POS_W   = 6;
  localparam int QTR_N   = 1 << (POS_W - 2);
  localparam int LVL_W   = 3;
  localparam int LVL_LSB = 4;

  // Value of each kind is the port address it drives
  typedef enum logic [1:0] {
    WK_CH1  = 2'b00,
    WK_CH2  = 2'b01,
    WK_LVL1 = 2'b10,
    WK_LVL2 = 2'b11
  } wrKind_e;

  typedef struct packed {
    logic    advance;
    logic    advUp;
    logic    load;
    logic    busActive;
    logic    strobeLow;
    wrKind_e kind;
  } seqStrobe_t;
endpackage

// File: rtl/ustep_wave_lut.sv
module ustep_wave_lut
  import ustep_pkg::*;
(
  input  logic [POS_W-1:0] pos,
  output logic [7:0]       ch1Code,
  output logic [7:0]       ch2Code
);
  localparam int NCH = 2;

  function automatic logic [6:0] quarterMag(input logic [POS_W-2:0] k);
    logic [6:0] m;
    case (k)
      5'd0:  m = 7'd0;
      5'd1:  m = 7'd12;
      5'd2:  m = 7'd25;
      5'd3:  m = 7'd37;
      5'd4:  m = 7'd49;
      5'd5:  m = 7'd60;
      5'd6:  m = 7'd71;
      5'd7:  m = 7'd81;
      5'd8:  m = 7'd90;
      5'd9:  m = 7'd98;
      5'd10: m = 7'd106;
      5'd11: m = 7'd112;
      5'd12: m = 7'd117;
      5'd13: m = 7'd122;
      5'd14: m = 7'd125;
      5'd15: m = 7'd126;
      default: m = 7'd127;
    endcase
    return m;
  endfunction

  logic [NCH-1:0][7:0] codes;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [POS_W-1:0] idx;
      logic [POS_W-2:0] fold;
      assign idx  = pos + POS_W'(c * QTR_N);
      assign fold = idx[POS_W-2] ? ((POS_W-1)'(QTR_N) - {1'b0, idx[POS_W-3:0]})
                                 : {1'b0, idx[POS_W-3:0]};
      assign codes[c] = {idx[POS_W-1], quarterMag(fold)};
    end
  endgenerate

  assign ch1Code = codes[0];
  assign ch2Code = codes[1];
endmodule

// File: rtl/ustep_ctrl.sv
module ustep_ctrl
  import ustep_pkg::*;
#(
  parameter int WR_LOW = 2,
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirUp,
  input  logic       singleMode,
  output seqStrobe_t stb,
  output logic       busy
);
  localparam int CNT_W  = (WR_LOW > 1) ? $clog2(WR_LOW) : 1;
  localparam int SUM_W  = PEND_W + 2;
  localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(WR_LOW - 1);
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'((1 << (PEND_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SUM_MIN = SUM_W'(-(1 << (PEND_W - 1)));

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HOLD} seqState_e;

  seqState_e                 state;
  logic [CNT_W-1:0]          lowCnt;
  wrKind_e                   curKind;
  logic                      chainNext;
  logic                      chanTurn;
  logic                      stepPrev;
  logic signed [PEND_W-1:0]  pendNet;
  logic                      sawStep;

  logic                      stepRise;
  logic                      consume;
  logic                      advUp;
  logic signed [SUM_W-1:0]   pendSum;
  logic signed [PEND_W-1:0]  pendNext;

  assign stepRise = stepIn & ~stepPrev;
  assign consume  = (state == S_IDLE) && (pendNet != '0);
  assign advUp    = ~pendNet[PEND_W-1];

  always_comb begin
    pendSum = {{2{pendNet[PEND_W-1]}}, pendNet};
    if (stepRise) pendSum = dirUp ? pendSum + SUM_W'(1) : pendSum - SUM_W'(1);
    if (consume)  pendSum = advUp ? pendSum - SUM_W'(1) : pendSum + SUM_W'(1);
    if (pendSum > SUM_MAX)      pendNext = SUM_MAX[PEND_W-1:0];
    else if (pendSum < SUM_MIN) pendNext = SUM_MIN[PEND_W-1:0];
    else                        pendNext = pendSum[PEND_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      pendNet  <= '0;
    end else begin
      stepPrev <= stepIn;
      pendNet  <= pendNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_LOW;
      lowCnt    <= '0;
      curKind   <= WK_LVL1;
      chainNext <= 1'b1;
      chanTurn  <= 1'b0;
      sawStep   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (consume) begin
          state   <= S_LOW;
          lowCnt  <= '0;
          sawStep <= 1'b1;
          if (singleMode) begin
            curKind   <= chanTurn ? WK_CH2 : WK_CH1;
            chanTurn  <= ~chanTurn;
            chainNext <= 1'b0;
          end else begin
            curKind   <= WK_CH1;
            chainNext <= 1'b1;
          end
        end
        S_LOW: begin
          if (lowCnt == LOW_LAST) state <= S_HOLD;
          else                    lowCnt <= lowCnt + CNT_W'(1);
        end
        S_HOLD: begin
          if (chainNext) begin
            state     <= S_LOW;
            lowCnt    <= '0;
            curKind   <= wrKind_e'({curKind[1], 1'b1});
            chainNext <= 1'b0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.advance   = consume;
    stb.advUp     = advUp;
    stb.load      = (state == S_LOW) && (lowCnt == '0);
    stb.busActive = (state != S_IDLE);
    stb.strobeLow = (state == S_LOW);
    stb.kind      = curKind;
  end

  assign busy = (state != S_IDLE) || (pendNet != '0);

  // R1: threshold writes never follow the first step write
  a_r1_levels_first: assert property (@(posedge clk) disable iff (!rstN)
    sawStep |-> !(stb.load && curKind[1]));

  // R5: a double-mode winding 1 write is followed directly by the winding 2 write
  a_r5_pair_chain: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && curKind == WK_CH1 && chainNext) |=> (stb.load && curKind == WK_CH2));

  // R7: a queued step is served only from idle, and serving starts a write
  a_r7_serve_starts_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (stb.load && !curKind[1]));
endmodule

// File: rtl/ustep_datapath.sv
module ustep_datapath
  import ustep_pkg::*;
#(
  parameter int WR_LOW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [LVL_W-1:0] lvl1,
  input  logic [LVL_W-1:0] lvl2,
  output logic             csN,
  output logic             wrN,
  output logic [1:0]       addr,
  output logic [7:0]       dataOut
);
  localparam int RUN_W = $clog2(WR_LOW + 2);

  logic [POS_W-1:0] posReg;
  logic [7:0]       ch1Code;
  logic [7:0]       ch2Code;
  logic [7:0]       nextData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            posReg <= '0;
    else if (stb.advance) posReg <= stb.advUp ? posReg + POS_W'(1) : posReg - POS_W'(1);
  end

  ustep_wave_lut u_lut (
    .pos     (posReg),
    .ch1Code (ch1Code),
    .ch2Code (ch2Code)
  );

  function automatic logic [7:0] lvlByte(input logic [LVL_W-1:0] lv);
    logic [7:0] b;
    b = '0;
    b[LVL_LSB +: LVL_W] = lv;
    return b;
  endfunction

  always_comb begin
    case (stb.kind)
      WK_CH1:  nextData = ch1Code;
      WK_CH2:  nextData = ch2Code;
      WK_LVL1: nextData = lvlByte(lvl1);
      default: nextData = lvlByte(lvl2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= 1'b1;
      wrN     <= 1'b1;
      addr    <= '0;
      dataOut <= '0;
    end else begin
      csN <= ~stb.busActive;
      wrN <= ~stb.strobeLow;
      if (stb.load) begin
        addr    <= stb.kind;
        dataOut <= nextData;
      end
    end
  end

  // Checker state: length of the current low run of the strobe
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    lowRun <= '0;
    else if (wrN) lowRun <= '0;
    else          lowRun <= lowRun + RUN_W'(1);
  end

  a_r2_strobe_in_select: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !csN);

  a_r2_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |=> ($stable(dataOut) && $stable(addr) && !csN));

  a_r2_low_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> (lowRun == RUN_W'(WR_LOW)));

  a_r3_pos_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (posReg != $past(posReg)) |->
      ((posReg == POS_W'($past(posReg) + 1'b1)) || (posReg == POS_W'($past(posReg) - 1'b1))));
endmodule

// File: rtl/ustep_write_seq.sv
module ustep_write_seq
  import ustep_pkg::*;
#(
  parameter int WR_LOW = 2,
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirUp,
  input  logic       singleMode,
  input  logic [2:0] lvl1,
  input  logic [2:0] lvl2,
  output logic       csN,
  output logic       wrN,
  output logic [1:0] addr,
  output logic [7:0] dataOut,
  output logic       busy
);
  seqStrobe_t stb;

  ustep_ctrl #(.WR_LOW(WR_LOW), .PEND_W(PEND_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stepIn     (stepIn),
    .dirUp      (dirUp),
    .singleMode (singleMode),
    .stb        (stb),
    .busy       (busy)
  );

  ustep_datapath #(.WR_LOW(WR_LOW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .lvl1    (lvl1),
    .lvl2    (lvl2),
    .csN     (csN),
    .wrN     (wrN),
    .addr    (addr),
    .dataOut (dataOut)
  );
endmodule

// File: tb/ustep_write_seq_bench.sv
`timescale 1ns/1ps
module ustep_write_seq_bench;
  localparam int WR_LOW = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepIn = 1'b0;
  logic       dirUp = 1'b1;
  logic       singleMode = 1'b0;
  logic [2:0] lvl1 = 3'd5;
  logic [2:0] lvl2 = 3'd2;
  logic       csN, wrN, busy;
  logic [1:0] addr;
  logic [7:0] dataOut;

  always #4 clk = ~clk;

  ustep_write_seq #(.WR_LOW(WR_LOW), .PEND_W(4)) u_ustep_write_seq (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirUp(dirUp), .singleMode(singleMode),
    .lvl1(lvl1), .lvl2(lvl2), .csN(csN), .wrN(wrN), .addr(addr), .dataOut(dataOut),
    .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int curPos = 0;
  bit finished = 0;

  int   cyc = 0;
  int   lowRun = 0;
  logic prevWr = 1'b1;
  int   logCnt = 0;
  logic [1:0] logAddr [512];
  logic [7:0] logData [512];
  int         logCyc  [512];
  int         logLow  [512];

  always @(negedge clk) begin
    cyc++;
    if (!wrN) lowRun++;
    if (rstN && !csN && wrN && !prevWr && logCnt < 512) begin
      logAddr[logCnt] = addr;
      logData[logCnt] = dataOut;
      logCyc[logCnt]  = cyc;
      logLow[logCnt]  = lowRun;
      logCnt++;
    end
    if (wrN) lowRun = 0;
    prevWr = wrN;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int ch, input int p);
    real ang, v;
    int  mag, s;
    ang = 2.0 * 3.14159265358979 * p / 64.0;
    v   = (ch == 0) ? $sin(ang) : $cos(ang);
    if (v < 0.0) v = -v;
    mag = $rtoi(v * 127.0 + 0.5);
    s   = (ch == 0) ? (p >= 32) : (p >= 16 && p < 48);
    return s * 128 + mag;
  endfunction

  task automatic stepOnce(input logic up);
    @(negedge clk);
    dirUp  = up;
    stepIn = 1'b1;
    @(negedge clk);
    stepIn = 1'b0;
    curPos = up ? (curPos + 1) % 64 : (curPos + 63) % 64;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkWrite(input string req, input int i, input int ch, input int p);
    chk({req, " addr"}, logAddr[i], ch);
    chk({req, " data"}, logData[i], expCode(ch, p));
    chk("R2 strobe low length", logLow[i], WR_LOW);
  endtask

  task automatic checkPair(input string req, input int i, input int p);
    checkWrite(req, i, 0, p);
    checkWrite(req, i + 1, 1, p);
    chk("R5 back-to-back gap", logCyc[i + 1] - logCyc[i], WR_LOW + 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset csN", csN, 1);
    chk("R1 reset wrN", wrN, 1);
    chk("R1 reset dataOut", dataOut, 0);
    rstN = 1'b1;
    waitIdle();
  endtask

  task automatic testInit();
    chk("R1 init write count", logCnt, 2);
    chk("R1 level1 addr", logAddr[0], 2);
    chk("R1 level1 data", logData[0], 8'h50);
    chk("R1 level2 addr", logAddr[1], 3);
    chk("R1 level2 data", logData[1], 8'h20);
    chk("R2 init strobe low", logLow[0], WR_LOW);
    chk("R8 idle after init", busy, 0);
  endtask

  task automatic testDoubleUp();
    for (int n = 0; n < 3; n++) begin
      int base = logCnt;
      stepOnce(1'b1);
      waitIdle();
      chk("R5 writes per double step", logCnt - base, 2);
      checkPair("R3 R4 up", base, curPos);
    end
  endtask

  task automatic testDownWrap();
    for (int n = 0; n < 4; n++) begin
      int base = logCnt;
      stepOnce(1'b0);
      waitIdle();
      checkPair("R3 R4 down", base, curPos);
    end
    chk("R3 wrapped position", curPos, 63);
  endtask

  task automatic testSweep();
    for (int n = 0; n < 64; n++) begin
      int base = logCnt;
      stepOnce(1'b1);
      waitIdle();
      checkPair("R4 sweep", base, curPos);
    end
  endtask

  task automatic testSingle();
    int base;
    singleMode = 1'b1;
    for (int n = 0; n < 3; n++) begin
      base = logCnt;
      stepOnce(1'b1);
      waitIdle();
      chk("R6 one write per step", logCnt - base, 1);
      checkWrite("R6 alternate", base, n % 2, curPos);
    end
    singleMode = 1'b0;
    base = logCnt;
    stepOnce(1'b1);
    waitIdle();
    checkPair("R5 double between singles", base, curPos);
    singleMode = 1'b1;
    base = logCnt;
    stepOnce(1'b1);
    waitIdle();
    chk("R6 one write after double", logCnt - base, 1);
    checkWrite("R6 turn kept across double", base, 1, curPos);
    singleMode = 1'b0;
  endtask

  task automatic testBurst();
    int base = logCnt;
    int startPos = curPos;
    for (int n = 0; n < 4; n++) stepOnce(1'b1);
    chk("R8 busy during burst", busy, 1);
    waitIdle();
    chk("R7 burst write count", logCnt - base, 8);
    for (int n = 0; n < 4; n++) checkPair("R7 burst order", base + 2 * n, (startPos + 1 + n) % 64);
  endtask

  task automatic testCancel();
    int base = logCnt;
    stepOnce(1'b1);
    chk("R8 busy after step", busy, 1);
    stepOnce(1'b1);
    stepOnce(1'b0);
    waitIdle();
    chk("R7 cancelled steps add no writes", logCnt - base, 2);
    checkPair("R7 served step", base, curPos);
    base = logCnt;
    stepOnce(1'b1);
    waitIdle();
    checkPair("R7 position after cancel", base, curPos);
  endtask

  task automatic testQuiet();
    int base = logCnt;
    repeat (20) @(negedge clk);
    chk("R9 no writes when idle", logCnt - base, 0);
    chk("R9 csN idle", csN, 1);
    chk("R9 wrN idle", wrN, 1);
    chk("R8 busy idle", busy, 0);
  endtask

  initial begin
    testReset();
    testInit();
    testDoubleUp();
    testDownWrap();
    testSweep();
    testSingle();
    testBurst();
    testCancel();
    testQuiet();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule